// File: doc/BRIEF.md
# SGI Source-Tracking Pending Controller

This block tracks software-generated interrupts (SGIs) in a multi-CPU interrupt controller. For each of the 16 SGI numbers and each target CPU, it keeps an 8-bit source bitmap. Bit k of that bitmap is set while CPU k has an outstanding request for that SGI on that target. Next to the bitmap sits an overall pending flag. One CPU raises an SGI on a group of targets through a 32-bit generate write. Software can also inspect, set or clear individual source bits through byte-wide registers. A CPU takes an interrupt by acknowledging it. Each acknowledge consumes exactly one source. The returned identifier carries the number of that source CPU, so one SGI raised by several CPUs is delivered once per requester.

Each CPU also has a running interrupt and a running priority. An acknowledge is granted only to a pending SGI whose priority value is strictly below the running priority. A lower value means a more urgent interrupt. A successful acknowledge records the interrupted running ID as the last-active value, and an end-of-interrupt write restores it. A legacy mode turns off the byte registers and makes acknowledges consume the whole SGI at once.

All requests arrive through one register port and one acknowledge request line per CPU. Work is serialised, one operation per cycle. Read data and acknowledge results are registered.

Top module: `sgi_src_tracker`

## Requirements
- R1: After reset, every source bitmap, pending flag and running state is cleared. Running IDs read 1023 and running priorities are idle, so an acknowledge returns 1023 and every register read returns 0.
- R2: A write to offset 0xF00 takes the SGI ID from data bits 9:0 and the target set from data bits 16+k, one bit per CPU k. For each target it sets the writer's bit in that target's bitmap and marks the SGI pending. IDs of 16 or more have no effect.
- R3: A byte write to offset 0xF10+n clears, in the accessing CPU's bitmap for SGI n, every bit that is set in data bits 7:0. The pending flag drops when the bitmap becomes zero.
- R4: A byte write to offset 0xF20+n ORs data bits 7:0 into the accessing CPU's bitmap for SGI n and sets the SGI pending. This happens even when the data is zero.
- R5: A read in either byte range returns the accessing CPU's bitmap for SGI n in bits 7:0, with all other bits zero. Any other address reads 0. Read data is valid the cycle after the request.
- R6: An acknowledge considers the pending SGIs of its CPU and picks the one with the lowest priority value, with ties going to the lower ID. It returns 1023 when nothing is pending or when that priority value is greater than or equal to the CPU's running priority.
- R7: A granted acknowledge picks the lowest-numbered set source bit, clears it, and returns ID | (source << 10) on a 13-bit identifier. An SGI that is pending with an empty bitmap is returned with source 0.
- R8: After an acknowledge, the SGI stays pending on that CPU while any source bit remains. It stops being pending only when the bitmap is empty.
- R9: A granted acknowledge stores the CPU's previous running ID as the last-active value of that SGI and CPU. It then makes the SGI running at its priority. A write to offset 0xF04 (end of interrupt) restores the running ID to that last-active value, with idle priority when the restored ID is 1023.
- R10: In legacy mode, offsets 0xF10–0xF2F are ignored and read as 0. An acknowledge clears the whole bitmap and the pending flag, and returns the plain ID with source field 0.
- R11: At most one acknowledge is granted per cycle. The grant goes to the lowest CPU index that is requesting, and no grant is given in a cycle with a valid register access. The result, tagged with the CPU number, appears the cycle after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| legacy_i | input | 1 | Legacy configuration mode |
| sgi_prio_i | input | 16*PRIO_W | Priority value of each SGI, SGI n at bits n*PRIO_W |
| reg_valid_i | input | 1 | Register access request |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_cpu_i | input | CPU_W | Number of the accessing CPU |
| reg_addr_i | input | ADDR_W | Byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rvalid_o | output | 1 | Read data valid |
| reg_rdata_o | output | 32 | Read data |
| ack_req_i | input | NUM_CPU | Acknowledge request, one bit per CPU, held until granted |
| ack_gnt_o | output | NUM_CPU | One-hot grant of this cycle |
| ack_valid_o | output | 1 | Acknowledge result valid |
| ack_cpu_o | output | CPU_W | CPU the result belongs to |
| ack_id_o | output | 13 | Source in bits 12:10, ID in bits 9:0, 1023 when spurious |

## Verification
Single sources are contrasted with one SGI raised by two CPUs. The first case shows that one acknowledge consumes one source. The second shows that a second acknowledge is refused until end of interrupt and then delivers the next source. Byte-register sequences separate set, partial clear and clear-to-empty, including a set with zero data that leaves the SGI pending with no source. Priority patterns include a more urgent SGI that arrives while a less urgent one is running, which tells preemption apart from equal-priority refusal. They also include two pending SGIs of different urgency, which checks the selection order. Legacy-mode runs and simultaneous requests from several CPUs check the mode switch and the grant order.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
   localparam int NSGI      = 16;
   localparam int SGI_W     = 4;
   localparam int ID_W      = 10;
   localparam int SRC_W     = 3;
   localparam int MAX_CPU   = 8;
   localparam int ACK_W     = ID_W + SRC_W;
   localparam logic [ID_W-1:0] SPURIOUS = 10'd1023;

   typedef logic [MAX_CPU-1:0] src_map_t;

   typedef struct packed {
      logic [SRC_W-1:0] src;
      logic [ID_W-1:0]  id;
   } ack_word_t;
endpackage

// File: rtl/sgi_lowbit.sv
module sgi_lowbit #(
   parameter int W  = 8,
   parameter int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  bits_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (bits_i[i]) begin
            any_o = 1'b1;
            idx_o = IW'(i);
         end
      end
   end
endmodule

// File: rtl/sgi_arb.sv
module sgi_arb #(
   parameter int N  = 4,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [N-1:0]  req_i,
   input  logic          block_i,
   output logic [N-1:0]  gnt_o,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      gnt_o = '0;
      any_o = 1'b0;
      idx_o = '0;
      if (!block_i) begin
         for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
               any_o = 1'b1;
               idx_o = IW'(i);
            end
         end
         if (any_o) gnt_o[idx_o] = 1'b1;
      end
   end

   // R11: never more than one grant, and only to a requester
   p_gnt_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gnt_o));
   p_gnt_subset_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_o & ~req_i) == '0);
   p_gnt_blocked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      block_i |-> gnt_o == '0);
endmodule

// File: rtl/sgi_pick.sv
module sgi_pick
   import sgi_pkg::*;
#(
   parameter int PRIO_W = 8
) (
   input  logic [NSGI-1:0]        pend_i,
   input  logic [NSGI*PRIO_W-1:0] prio_i,
   input  logic [PRIO_W:0]        run_prio_i,
   output logic                   take_o,
   output logic [SGI_W-1:0]       id_o
);
   logic              found;
   logic [PRIO_W-1:0] best_v;

   always_comb begin
      found  = 1'b0;
      best_v = '1;
      id_o   = '0;
      for (int s = 0; s < NSGI; s++) begin
         if (pend_i[s] && (!found || prio_i[s*PRIO_W +: PRIO_W] < best_v)) begin
            found  = 1'b1;
            best_v = prio_i[s*PRIO_W +: PRIO_W];
            id_o   = SGI_W'(s);
         end
      end
      take_o = found && ({1'b0, best_v} < run_prio_i);
   end
endmodule

// File: rtl/sgi_src_tracker.sv
module sgi_src_tracker
   import sgi_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int PRIO_W  = 8,
   parameter int ADDR_W  = 12,
   parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
   parameter logic [ADDR_W-1:0] GEN_OFS  = 'hF00,
   parameter logic [ADDR_W-1:0] EOI_OFS  = 'hF04,
   parameter logic [ADDR_W-1:0] CLR_BASE = 'hF10,
   parameter logic [ADDR_W-1:0] SET_BASE = 'hF20
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   legacy_i,
   input  logic [NSGI*PRIO_W-1:0] sgi_prio_i,
   input  logic                   reg_valid_i,
   input  logic                   reg_write_i,
   input  logic [CPU_W-1:0]       reg_cpu_i,
   input  logic [ADDR_W-1:0]      reg_addr_i,
   input  logic [31:0]            reg_wdata_i,
   output logic                   reg_rvalid_o,
   output logic [31:0]            reg_rdata_o,
   input  logic [NUM_CPU-1:0]     ack_req_i,
   output logic [NUM_CPU-1:0]     ack_gnt_o,
   output logic                   ack_valid_o,
   output logic [CPU_W-1:0]       ack_cpu_o,
   output logic [ACK_W-1:0]       ack_id_o
);
   localparam logic [PRIO_W:0] IDLE = {1'b1, {PRIO_W{1'b0}}};

   if (NUM_CPU < 1 || NUM_CPU > MAX_CPU) begin : g_bad_cpu
      $error("NUM_CPU must lie in 1..8");
   end
   if (PRIO_W < 1) begin : g_bad_prio
      $error("PRIO_W must be positive");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W must hold the register offsets");
   end

   // state
   src_map_t          mask_q  [NSGI][NUM_CPU];
   logic              pend_q  [NSGI][NUM_CPU];
   logic [ID_W-1:0]   last_q  [NSGI][NUM_CPU];
   logic [ID_W-1:0]   run_id_q   [NUM_CPU];
   logic [PRIO_W:0]   run_prio_q [NUM_CPU];
   logic              rvalid_q;
   logic [31:0]       rdata_q;
   logic              avalid_q;
   logic [CPU_W-1:0]  acpu_q;
   ack_word_t         aword_q;

   function automatic logic [PRIO_W-1:0] prio_of(input logic [SGI_W-1:0] s);
      return sgi_prio_i[s*PRIO_W +: PRIO_W];
   endfunction

   // register decode
   logic             is_gen, is_eoi, is_clr, is_set, byte_ok;
   logic [SGI_W-1:0] bidx;
   logic [ID_W-1:0]  gen_id;
   src_map_t         wr_src_oh, cur_byte, clr_left;

   assign is_gen  = reg_addr_i == GEN_OFS;
   assign is_eoi  = reg_addr_i == EOI_OFS;
   assign is_clr  = reg_addr_i[ADDR_W-1:4] == CLR_BASE[ADDR_W-1:4];
   assign is_set  = reg_addr_i[ADDR_W-1:4] == SET_BASE[ADDR_W-1:4];
   assign byte_ok = (is_clr || is_set) && !legacy_i;
   assign bidx    = reg_addr_i[SGI_W-1:0];
   assign gen_id  = reg_wdata_i[ID_W-1:0];
   assign wr_src_oh = src_map_t'(1) << reg_cpu_i;
   assign cur_byte  = mask_q[bidx][reg_cpu_i];
   assign clr_left  = cur_byte & ~reg_wdata_i[7:0];

   // end of interrupt lookup
   logic [ID_W-1:0] cur_run, back_id;
   logic [PRIO_W:0] back_prio;
   assign cur_run   = run_id_q[reg_cpu_i];
   assign back_id   = last_q[cur_run[SGI_W-1:0]][reg_cpu_i];
   assign back_prio = (back_id == SPURIOUS) ? IDLE : {1'b0, prio_of(back_id[SGI_W-1:0])};

   // per-CPU selection
   logic             take_w [NUM_CPU];
   logic [SGI_W-1:0] id_w   [NUM_CPU];

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic [NSGI-1:0] pend_row;
      for (genvar s = 0; s < NSGI; s++) begin : g_row
         assign pend_row[s] = pend_q[s][c];
      end
      sgi_pick #(.PRIO_W(PRIO_W)) u_pick (
         .pend_i     (pend_row),
         .prio_i     (sgi_prio_i),
         .run_prio_i (run_prio_q[c]),
         .take_o     (take_w[c]),
         .id_o       (id_w[c])
      );
   end

   // acknowledge arbitration and source choice
   logic             arb_any;
   logic [CPU_W-1:0] arb_idx;
   logic             sel_take;
   logic [SGI_W-1:0] sel_id;
   src_map_t         sel_mask, src_oh, rem_mask;
   logic             src_any;
   logic [SRC_W-1:0] src_idx;

   sgi_arb #(.N(NUM_CPU), .IW(CPU_W)) u_arb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (ack_req_i),
      .block_i (reg_valid_i),
      .gnt_o   (ack_gnt_o),
      .any_o   (arb_any),
      .idx_o   (arb_idx)
   );

   assign sel_take = take_w[arb_idx];
   assign sel_id   = id_w[arb_idx];
   assign sel_mask = mask_q[sel_id][arb_idx];

   sgi_lowbit #(.W(MAX_CPU), .IW(SRC_W)) u_low (
      .bits_i (sel_mask),
      .any_o  (src_any),
      .idx_o  (src_idx)
   );

   assign src_oh   = src_any ? (src_map_t'(1) << src_idx) : '0;
   assign rem_mask = sel_mask & ~src_oh;

   // read data
   logic [31:0] rd_val;
   assign rd_val = byte_ok ? {24'b0, cur_byte} : 32'b0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < NSGI; s++) begin
            for (int c = 0; c < NUM_CPU; c++) begin
               mask_q[s][c] <= '0;
               pend_q[s][c] <= 1'b0;
               last_q[s][c] <= SPURIOUS;
            end
         end
         for (int c = 0; c < NUM_CPU; c++) begin
            run_id_q[c]   <= SPURIOUS;
            run_prio_q[c] <= IDLE;
         end
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
         avalid_q <= 1'b0;
         acpu_q   <= '0;
         aword_q  <= '{src: '0, id: SPURIOUS};
      end else begin
         rvalid_q <= reg_valid_i && !reg_write_i;
         rdata_q  <= (reg_valid_i && !reg_write_i) ? rd_val : 32'b0;
         avalid_q <= arb_any;

         if (reg_valid_i && reg_write_i) begin
            if (is_gen) begin
               if (gen_id < ID_W'(NSGI)) begin
                  for (int t = 0; t < NUM_CPU; t++) begin
                     if (reg_wdata_i[16+t]) begin
                        mask_q[gen_id[SGI_W-1:0]][t] <= mask_q[gen_id[SGI_W-1:0]][t] | wr_src_oh;
                        pend_q[gen_id[SGI_W-1:0]][t] <= 1'b1;
                     end
                  end
               end
            end else if (is_eoi) begin
               if (cur_run != SPURIOUS) begin
                  run_id_q[reg_cpu_i]   <= back_id;
                  run_prio_q[reg_cpu_i] <= back_prio;
               end
            end else if (byte_ok && is_clr) begin
               mask_q[bidx][reg_cpu_i] <= clr_left;
               if (clr_left == '0) pend_q[bidx][reg_cpu_i] <= 1'b0;
            end else if (byte_ok && is_set) begin
               mask_q[bidx][reg_cpu_i] <= cur_byte | reg_wdata_i[7:0];
               pend_q[bidx][reg_cpu_i] <= 1'b1;
            end
         end

         if (arb_any) begin
            acpu_q <= arb_idx;
            if (sel_take) begin
               last_q[sel_id][arb_idx] <= run_id_q[arb_idx];
               run_id_q[arb_idx]       <= ID_W'(sel_id);
               run_prio_q[arb_idx]     <= {1'b0, prio_of(sel_id)};
               if (legacy_i) begin
                  mask_q[sel_id][arb_idx] <= '0;
                  pend_q[sel_id][arb_idx] <= 1'b0;
                  aword_q <= '{src: '0, id: ID_W'(sel_id)};
               end else begin
                  mask_q[sel_id][arb_idx] <= rem_mask;
                  if (rem_mask == '0) pend_q[sel_id][arb_idx] <= 1'b0;
                  aword_q <= '{src: src_idx, id: ID_W'(sel_id)};
               end
            end else begin
               aword_q <= '{src: '0, id: SPURIOUS};
            end
         end
      end
   end

   assign reg_rvalid_o = rvalid_q;
   assign reg_rdata_o  = rdata_q;
   assign ack_valid_o  = avalid_q;
   assign ack_cpu_o    = acpu_q;
   assign ack_id_o     = aword_q;

   // R8: a non-empty bitmap always keeps its SGI pending
   for (genvar s = 0; s < NSGI; s++) begin : g_chk_s
      for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk_c
         p_pend_covers_map_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            mask_q[s][c] != '0 |-> pend_q[s][c]);
      end
   end

   // R7: the reported source is no longer set once the result is out
   p_src_consumed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_valid_o && ack_id_o[ID_W-1:0] != SPURIOUS)
      |-> mask_q[ack_id_o[SGI_W-1:0]][ack_cpu_o][ack_id_o[ACK_W-1:ID_W]] == 1'b0);

   // R9: a granted acknowledge leaves a non-idle running priority
   p_run_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_valid_o && ack_id_o[ID_W-1:0] != SPURIOUS) |-> run_prio_q[ack_cpu_o] != IDLE);

   // R10: legacy reads return zero
   p_legacy_rd_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(reg_valid_i && !reg_write_i && legacy_i) |-> reg_rdata_o == 32'b0);

   // R5: read data valid exactly one cycle after a read request
   p_rvalid_timing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(reg_valid_i && !reg_write_i) |-> reg_rvalid_o);
endmodule

// File: tb/tb_sgi_src_tracker.sv
`timescale 1ns/1ps
module tb_sgi_src_tracker;
   localparam int NCPU = 4;
   localparam int NV   = 62;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         legacy = 1'b0;
   logic [127:0] prio;
   logic         reg_valid = 1'b0, reg_write = 1'b0;
   logic [1:0]   reg_cpu = '0;
   logic [11:0]  reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic         rvalid;
   logic [31:0]  rdata;
   logic [NCPU-1:0] ack_req = '0, ack_gnt;
   logic         ack_valid;
   logic [1:0]   ack_cpu;
   logic [12:0]  ack_id;

   int n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   sgi_src_tracker #(.NUM_CPU(NCPU), .PRIO_W(8)) dut (
      .clk_i(clk), .rst_ni(rst_n), .legacy_i(legacy), .sgi_prio_i(prio),
      .reg_valid_i(reg_valid), .reg_write_i(reg_write), .reg_cpu_i(reg_cpu),
      .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
      .reg_rvalid_o(rvalid), .reg_rdata_o(rdata),
      .ack_req_i(ack_req), .ack_gnt_o(ack_gnt), .ack_valid_o(ack_valid),
      .ack_cpu_o(ack_cpu), .ack_id_o(ack_id)
   );

   // {op(2) cpu(3) legacy(1) addr(12) data(32) expect(16)}; op 0 write, 1 read, 2 ack
   localparam logic [65:0] VEC [NV] = '{
      {2'd0,3'd1,1'b0,12'hF00,32'h00050003,16'h0000}, // R2
      {2'd0,3'd2,1'b0,12'hF00,32'h00050003,16'h0000}, // R2
      {2'd1,3'd0,1'b0,12'hF13,32'h0,16'h0006},        // R2 R5
      {2'd1,3'd2,1'b0,12'hF23,32'h0,16'h0006},        // R5
      {2'd1,3'd1,1'b0,12'hF13,32'h0,16'h0000},        // R2 non-target
      {2'd2,3'd0,1'b0,12'h000,32'h0,16'h0403},        // R7 lowest source
      {2'd1,3'd0,1'b0,12'hF13,32'h0,16'h0004},        // R7 R8
      {2'd2,3'd0,1'b0,12'h000,32'h0,16'h03FF},        // R6 equal priority
      {2'd0,3'd0,1'b0,12'hF04,32'h0,16'h0000},        // R9 eoi
      {2'd2,3'd0,1'b0,12'h000,32'h0,16'h0803},        // R7 next source
      {2'd2,3'd0,1'b0,12'h000,32'h0,16'h03FF},        // R6
      {2'd0,3'd0,1'b0,12'hF04,32'h0,16'h0000},
      {2'd2,3'd0,1'b0,12'h000,32'h0,16'h03FF},        // R8 drained
      {2'd0,3'd3,1'b0,12'hF25,32'h00000081,16'h0000}, // R4
      {2'd1,3'd3,1'b0,12'hF15,32'h0,16'h0081},        // R4 R5
      {2'd0,3'd3,1'b0,12'hF15,32'h00000001,16'h0000}, // R3
      {2'd1,3'd3,1'b0,12'hF25,32'h0,16'h0080},        // R3
      {2'd0,3'd0,1'b0,12'hF00,32'h00080003,16'h0000}, // R2
      {2'd2,3'd3,1'b0,12'h000,32'h0,16'h1C05},        // R6 R7 source 7
      {2'd2,3'd3,1'b0,12'h000,32'h0,16'h03FF},        // R6 lower urgency
      {2'd0,3'd3,1'b0,12'hF04,32'h0,16'h0000},        // R9
      {2'd2,3'd3,1'b0,12'h000,32'h0,16'h0003},        // R7 source 0
      {2'd2,3'd3,1'b0,12'h000,32'h0,16'h03FF},
      {2'd0,3'd3,1'b0,12'hF04,32'h0,16'h0000},
      {2'd2,3'd2,1'b0,12'h000,32'h0,16'h0403},        // R7
      {2'd0,3'd1,1'b0,12'hF00,32'h00040005,16'h0000}, // R2
      {2'd2,3'd2,1'b0,12'h000,32'h0,16'h0405},        // R6 preempt
      {2'd0,3'd2,1'b0,12'hF04,32'h0,16'h0000},        // R9 back to 3
      {2'd2,3'd2,1'b0,12'h000,32'h0,16'h03FF},        // R9 restored priority
      {2'd0,3'd2,1'b0,12'hF04,32'h0,16'h0000},        // R9 back to idle
      {2'd2,3'd2,1'b0,12'h000,32'h0,16'h0803},        // R9
      {2'd0,3'd2,1'b0,12'hF04,32'h0,16'h0000},
      {2'd0,3'd1,1'b0,12'hF22,32'h00000003,16'h0000}, // R4
      {2'd0,3'd1,1'b0,12'hF12,32'h00000003,16'h0000}, // R3 to empty
      {2'd2,3'd1,1'b0,12'h000,32'h0,16'h03FF},        // R3 pending dropped
      {2'd0,3'd1,1'b0,12'hF26,32'h00000000,16'h0000}, // R4 zero data
      {2'd1,3'd1,1'b0,12'hF26,32'h0,16'h0000},        // R4
      {2'd2,3'd1,1'b0,12'h000,32'h0,16'h0006},        // R7 empty map
      {2'd0,3'd1,1'b0,12'hF04,32'h0,16'h0000},
      {2'd2,3'd1,1'b0,12'h000,32'h0,16'h03FF},        // R8
      {2'd0,3'd0,1'b0,12'hF29,32'h00000004,16'h0000}, // R4
      {2'd0,3'd0,1'b0,12'hF27,32'h00000008,16'h0000}, // R4
      {2'd2,3'd0,1'b0,12'h000,32'h0,16'h0C07},        // R6 order
      {2'd2,3'd0,1'b0,12'h000,32'h0,16'h03FF},        // R6
      {2'd0,3'd0,1'b0,12'hF04,32'h0,16'h0000},
      {2'd2,3'd0,1'b0,12'h000,32'h0,16'h0809},        // R6
      {2'd0,3'd0,1'b0,12'hF04,32'h0,16'h0000},
      {2'd0,3'd0,1'b1,12'hF2A,32'h000000FF,16'h0000}, // R10 ignored
      {2'd1,3'd0,1'b1,12'hF2A,32'h0,16'h0000},        // R10
      {2'd1,3'd0,1'b0,12'hF2A,32'h0,16'h0000},        // R10 no effect
      {2'd2,3'd0,1'b0,12'h000,32'h0,16'h03FF},        // R10 no effect
      {2'd0,3'd1,1'b1,12'hF00,32'h00010004,16'h0000}, // R2
      {2'd0,3'd2,1'b1,12'hF00,32'h00010004,16'h0000}, // R2
      {2'd1,3'd0,1'b1,12'hF14,32'h0,16'h0000},        // R10 read zero
      {2'd2,3'd0,1'b1,12'h000,32'h0,16'h0004},        // R10 plain id
      {2'd0,3'd0,1'b1,12'hF04,32'h0,16'h0000},
      {2'd1,3'd0,1'b0,12'hF14,32'h0,16'h0000},        // R10 whole map gone
      {2'd2,3'd0,1'b0,12'h000,32'h0,16'h03FF},        // R10
      {2'd0,3'd1,1'b0,12'hF00,32'h000F0010,16'h0000}, // R2 id 16
      {2'd2,3'd0,1'b0,12'h000,32'h0,16'h03FF},        // R2
      {2'd2,3'd3,1'b0,12'h000,32'h0,16'h03FF},        // R2
      {2'd1,3'd0,1'b0,12'hF00,32'h0,16'h0000}         // R5 other address
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [1:0] c, input logic [11:0] a, input logic [31:0] d);
      reg_valid = 1'b1; reg_write = 1'b1; reg_cpu = c; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0;
   endtask

   task automatic do_read(input logic [1:0] c, input logic [11:0] a, input logic [31:0] exp, input string req);
      reg_valid = 1'b1; reg_write = 1'b0; reg_cpu = c; reg_addr = a;
      @(negedge clk);
      reg_valid = 1'b0;
      check({req, " rvalid"}, {31'b0, rvalid}, 32'd1);
      check(req, rdata, exp);
   endtask

   task automatic do_ack(input logic [1:0] c, input logic [12:0] exp, input string req);
      ack_req[c] = 1'b1;
      @(negedge clk);
      ack_req = '0;
      check({req, " cpu"}, {29'b0, ack_valid, ack_cpu}, {29'b0, 1'b1, c});
      check(req, {19'b0, ack_id}, {19'b0, exp});
   endtask

   initial begin
      #(200000 * 20);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int s = 0; s < 16; s++) prio[s*8 +: 8] = 8'h10 + 8'(s);
      prio[5*8 +: 8] = 8'h08;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rvalid idle", {31'b0, rvalid}, 32'd0);
      check("R1 ack idle", {31'b0, ack_valid}, 32'd0);
      do_read(2'd0, 12'hF13, 32'd0, "R1 map");
      do_ack(2'd0, 13'h3FF, "R1 ack");

      for (int i = 0; i < NV; i++) begin
         logic [65:0] v;
         v = VEC[i];
         legacy = v[60];
         case (v[65:64])
            2'd0: do_write(v[62:61], v[59:48], v[47:16]);
            2'd1: do_read(v[62:61], v[59:48], {16'b0, v[15:0]}, $sformatf("vec%0d", i));
            default: do_ack(v[62:61], v[12:0], $sformatf("vec%0d", i));
         endcase
      end
      legacy = 1'b0;

      // R11 simultaneous requests: lowest index first
      ack_req = 4'b1010;
      #1;
      check("R11 gnt", {28'b0, ack_gnt}, 32'h2);
      @(negedge clk);
      check("R11 first cpu", {30'b0, ack_cpu}, 32'd1);
      check("R11 first id", {19'b0, ack_id}, 32'h3FF);
      ack_req = 4'b1000;
      #1;
      check("R11 second gnt", {28'b0, ack_gnt}, 32'h8);
      @(negedge clk);
      check("R11 second cpu", {30'b0, ack_cpu}, 32'd3);
      // R11 register access blocks grant
      ack_req = 4'b0001;
      reg_valid = 1'b1; reg_write = 1'b0; reg_cpu = 2'd0; reg_addr = 12'hF00;
      #1;
      check("R11 blocked", {28'b0, ack_gnt}, 32'h0);
      @(negedge clk);
      reg_valid = 1'b0; ack_req = '0;
      check("R11 no result", {31'b0, ack_valid}, 32'd0);

      // R1 reset again clears a loaded map
      do_write(2'd2, 12'hF00, 32'h00010002);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      do_read(2'd0, 12'hF12, 32'd0, "R1 cleared");
      do_ack(2'd0, 13'h3FF, "R1 cleared ack");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule